// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block takes interrupt events from on-chip sources and stores each one as a 16-byte vector in a circular buffer in host memory. Each accepted event is packed into four dwords and issued as one 128-bit write request at `base + write pointer`. The write pointer then advances by 16 bytes and wraps at the programmed ring size. Software consumes vectors and reports its progress by writing a read pointer. The block raises an interrupt line while the two pointers differ or an overflow is being flagged.

Software programs the block through a small register port. The registers hold the control bits, the ring base (address bits 39:8, so the ring is 256-byte aligned), a 40-bit writeback address, and the two pointers. When overflow detection is on and a new vector fills the last free slot, the vector is still written. The write pointer still wraps, and a sticky flag appears in bit 0 of the reported write pointer. Software resumes reading at write pointer + 16 and clears the flag through a control bit. With writeback enabled, every pointer update is followed by a second request that stores the reported write pointer, including the flag, at the writeback address.

Register map (`cfg_addr`): 0 control, 1 base, 2 writeback address low, 3 writeback address high, 4 read pointer, 5 write pointer. Control bits: bit 0 ring enable, bit 1 interrupt enable, bit 2 overflow detect, bit 3 writeback enable, bit 4 rearm mode, bit 5 overflow clear (write-one, reads 0), bits 12:8 ring size as log2 of dwords.

Top module: `ivr_writer`

## Requirements
- R1: The vector data holds dword n at bits [32n+31:32n]. Dword 0 carries the source ID in [7:0] with zero above it. Dword 1 carries the 28-bit source data in [27:0] with zero above it. Dword 2 carries ring ID in [7:0], VMID in [15:8] and PASID in [31:16]. Dword 3 is zero.
- R2: A vector is written to address base*256 + write pointer. Each written vector advances the write pointer by 16, modulo a ring of 2^(size+2) bytes. The size field is clamped to the range 3..MAX_LOG2_DW.
- R3: `ev_ready` is high only when ring enable and interrupt enable are both set and no request is outstanding. Events offered while the ring is disabled cause no memory request and leave the write pointer unchanged.
- R4: With overflow detect set, a vector whose advanced write pointer equals the read pointer sets bit 0 of the reported write pointer. The vector is still written and the pointer still advances. With overflow detect clear, the flag never sets.
- R5: The overflow flag stays set, across read-pointer writes, until a control write with bit 5 set.
- R6: With writeback enabled, each vector request is followed by a request with `mem_req_wb`=1. That request goes to address {high[7:0], low[31:0]}, with data[31:0] equal to the reported write pointer and the upper data bits zero.
- R7: With rearm mode off, `irq` equals interrupt enable AND (write pointer != read pointer OR overflow flag).
- R8: With rearm mode on, `irq` is a single-cycle pulse. A read-pointer write re-arms it, and it pulses again on the next cycle if the ring is still non-empty.
- R9: Software writes to either pointer are masked to the ring size and to 16-byte alignment. Writing zero to both pointers empties the ring.
- R10: `busy` is high from the cycle after an event is accepted until the last request of that event completes.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request address and data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event accepted when high with `ev_valid` |
| ev_src_id | input | 8 | Event source ID |
| ev_src_data | input | 28 | Event source data |
| ev_ring_id | input | 8 | Event ring ID |
| ev_vmid | input | 8 | Event VMID |
| ev_pasid | input | 16 | Event PASID |
| mem_req_valid | output | 1 | Memory write request valid |
| mem_req_ready | input | 1 | Memory write request accepted |
| mem_req_addr | output | 40 | Byte address of the request |
| mem_req_data | output | 128 | Request data |
| mem_req_wb | output | 1 | 1 for a pointer writeback, 0 for a vector |
| irq | output | 1 | Interrupt to host |
| busy | output | 1 | A request is outstanding |

## Verification
Vectors are sent with distinct field patterns in each dword, so that a swapped or truncated field shows up in the packed data. Runs of writes into a four-slot ring cover the plain advance, the wrap to zero and the filling of the last slot. The last-slot case is run with overflow detect on and off, which separates the sticky flag from a plain wrap. With writeback on, each pointer update is matched against its mirror request. Rearm mode is compared with level mode by counting interrupt cycles around read-pointer writes. A stalled memory port and a disabled ring show that nothing is issued or lost when it should not be.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
    localparam int ADDR_W      = 40;
    localparam int VEC_W       = 128;
    localparam int VEC_BYTES   = 16;
    localparam int MIN_LOG2_DW = 3;

    localparam logic [2:0] REG_CTRL  = 3'd0;
    localparam logic [2:0] REG_BASE  = 3'd1;
    localparam logic [2:0] REG_WB_LO = 3'd2;
    localparam logic [2:0] REG_WB_HI = 3'd3;
    localparam logic [2:0] REG_RPTR  = 3'd4;
    localparam logic [2:0] REG_WPTR  = 3'd5;

    localparam int CB_RING    = 0;
    localparam int CB_INTR    = 1;
    localparam int CB_OVF     = 2;
    localparam int CB_WB      = 3;
    localparam int CB_REARM   = 4;
    localparam int CB_OVF_CLR = 5;
    localparam int CB_SIZE_LO = 8;

    typedef struct packed {
        logic [15:0] pasid;
        logic [7:0]  vmid;
        logic [7:0]  ring_id;
        logic [27:0] src_data;
        logic [7:0]  src_id;
    } ivr_event_t;

    typedef struct packed {
        logic       ring_en;
        logic       intr_en;
        logic       ovf_en;
        logic       wb_en;
        logic       rearm;
        logic [4:0] size_log2;
    } ivr_ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_VEC  = 2'd1,
        ST_WB   = 2'd2
    } ivr_state_t;

    // Four-dword vector image; the last dword stays zero.
    function automatic logic [VEC_W-1:0] pack_vector(ivr_event_t e);
        logic [31:0] w0, w1, w2, w3;
        w0 = {24'h0, e.src_id};
        w1 = {4'h0, e.src_data};
        w2 = {e.pasid, e.vmid, e.ring_id};
        w3 = 32'h0;
        return {w3, w2, w1, w0};
    endfunction
endpackage

// File: rtl/ivr_regs.sv
module ivr_regs
    import ivr_pkg::*;
#(
    parameter int MAX_LOG2_DW = 14,
    parameter int PTR_W       = MAX_LOG2_DW + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [31:0]       wptr_report,
    output logic              ring_en,
    output logic              intr_en,
    output logic              ovf_en,
    output logic              wb_en,
    output logic              rearm,
    output logic [31:0]       base,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [PTR_W-1:0]  rptr,
    output logic [PTR_W-1:0]  ptr_mask,
    output logic [PTR_W-1:0]  sw_ptr_val,
    output logic              wptr_wr,
    output logic              rptr_wr,
    output logic              ovf_clr
);
    localparam logic [PTR_W-1:0] ALIGN_MASK = ~PTR_W'(VEC_BYTES - 1);

    ivr_ctrl_t   ctrl_q;
    logic [31:0] base_q;
    logic [31:0] wb_lo_q;
    logic [7:0]  wb_hi_q;
    logic [PTR_W-1:0] rptr_q;
    logic [4:0]  size_eff;
    logic [PTR_W:0] span;

    always_comb begin
        if (ctrl_q.size_log2 < 5'(MIN_LOG2_DW))
            size_eff = 5'(MIN_LOG2_DW);
        else if (ctrl_q.size_log2 > 5'(MAX_LOG2_DW))
            size_eff = 5'(MAX_LOG2_DW);
        else
            size_eff = ctrl_q.size_log2;
    end

    assign span       = (PTR_W+1)'(1) << (size_eff + 5'd2);
    assign ptr_mask   = PTR_W'(span - (PTR_W+1)'(1));
    assign sw_ptr_val = cfg_wdata[PTR_W-1:0] & ptr_mask & ALIGN_MASK;

    assign wptr_wr = cfg_we && (cfg_addr == REG_WPTR);
    assign rptr_wr = cfg_we && (cfg_addr == REG_RPTR);
    assign ovf_clr = cfg_we && (cfg_addr == REG_CTRL) && cfg_wdata[CB_OVF_CLR];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            base_q  <= '0;
            wb_lo_q <= '0;
            wb_hi_q <= '0;
            rptr_q  <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                REG_CTRL: begin
                    ctrl_q.ring_en   <= cfg_wdata[CB_RING];
                    ctrl_q.intr_en   <= cfg_wdata[CB_INTR];
                    ctrl_q.ovf_en    <= cfg_wdata[CB_OVF];
                    ctrl_q.wb_en     <= cfg_wdata[CB_WB];
                    ctrl_q.rearm     <= cfg_wdata[CB_REARM];
                    ctrl_q.size_log2 <= cfg_wdata[CB_SIZE_LO +: 5];
                end
                REG_BASE:  base_q  <= cfg_wdata;
                REG_WB_LO: wb_lo_q <= cfg_wdata;
                REG_WB_HI: wb_hi_q <= cfg_wdata[7:0];
                REG_RPTR:  rptr_q  <= sw_ptr_val;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (cfg_addr)
            REG_CTRL:  cfg_rdata = {19'h0, ctrl_q.size_log2, 3'h0, ctrl_q.rearm,
                                    ctrl_q.wb_en, ctrl_q.ovf_en, ctrl_q.intr_en,
                                    ctrl_q.ring_en};
            REG_BASE:  cfg_rdata = base_q;
            REG_WB_LO: cfg_rdata = wb_lo_q;
            REG_WB_HI: cfg_rdata = {24'h0, wb_hi_q};
            REG_RPTR:  cfg_rdata = 32'(rptr_q);
            REG_WPTR:  cfg_rdata = wptr_report;
            default:   cfg_rdata = 32'h0;
        endcase
    end

    assign ring_en = ctrl_q.ring_en;
    assign intr_en = ctrl_q.intr_en;
    assign ovf_en  = ctrl_q.ovf_en;
    assign wb_en   = ctrl_q.wb_en;
    assign rearm   = ctrl_q.rearm;
    assign base    = base_q;
    assign wb_addr = {wb_hi_q, wb_lo_q};
    assign rptr    = rptr_q;
endmodule

// File: rtl/ivr_ctrl.sv
module ivr_ctrl
    import ivr_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ring_en,
    input  logic              intr_en,
    input  logic              ovf_en,
    input  logic              wb_en,
    input  logic [31:0]       base,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [PTR_W-1:0]  rptr,
    input  logic [PTR_W-1:0]  ptr_mask,
    input  logic [PTR_W-1:0]  sw_ptr_val,
    input  logic              wptr_wr,
    input  logic              ovf_clr,
    input  logic              ev_valid,
    input  ivr_event_t        ev,
    output logic              ev_ready,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [VEC_W-1:0]  mem_req_data,
    output logic              mem_req_wb,
    output logic              busy,
    output logic [PTR_W-1:0]  wptr,
    output logic              ovf_flag,
    output logic [31:0]       wptr_report
);
    ivr_state_t       state_q;
    logic [VEC_W-1:0] vec_q;
    logic [PTR_W-1:0] wptr_q;
    logic             ovf_q;
    logic [PTR_W-1:0] wptr_next;
    logic             ovf_hit;
    logic             vec_done;

    assign wptr_next   = (wptr_q + PTR_W'(VEC_BYTES)) & ptr_mask;
    assign ovf_hit     = ovf_en && (wptr_next == rptr);
    assign vec_done    = (state_q == ST_VEC) && mem_req_ready;
    assign wptr_report = 32'(wptr_q) | {31'h0, ovf_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
            wptr_q  <= '0;
            ovf_q   <= 1'b0;
        end else begin
            if (ovf_clr)
                ovf_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (ev_valid && ev_ready) begin
                    vec_q   <= pack_vector(ev);
                    state_q <= ST_VEC;
                end
                ST_VEC: if (vec_done) begin
                    wptr_q  <= wptr_next;
                    if (ovf_hit)
                        ovf_q <= 1'b1;
                    state_q <= wb_en ? ST_WB : ST_IDLE;
                end
                ST_WB: if (mem_req_ready)
                    state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
            if (wptr_wr)
                wptr_q <= sw_ptr_val;
        end
    end

    always_comb begin
        ev_ready      = ring_en && intr_en && (state_q == ST_IDLE);
        busy          = (state_q != ST_IDLE);
        mem_req_valid = (state_q != ST_IDLE);
        mem_req_wb    = (state_q == ST_WB);
        if (state_q == ST_WB) begin
            mem_req_addr = wb_addr;
            mem_req_data = {96'h0, wptr_report};
        end else begin
            mem_req_addr = {base, 8'h00} + ADDR_W'(wptr_q);
            mem_req_data = vec_q;
        end
    end

    assign wptr     = wptr_q;
    assign ovf_flag = ovf_q;
endmodule

// File: rtl/ivr_irq.sv
module ivr_irq (
    input  logic clk,
    input  logic rst,
    input  logic intr_en,
    input  logic rearm,
    input  logic pending,
    input  logic rptr_wr,
    output logic irq
);
    logic armed_q;

    assign irq = intr_en && pending && armed_q;

    always_ff @(posedge clk) begin
        if (rst)
            armed_q <= 1'b1;
        else if (rptr_wr || !rearm)
            armed_q <= 1'b1;
        else if (irq)
            armed_q <= 1'b0;
    end
endmodule

// File: rtl/ivr_writer.sv
module ivr_writer
    import ivr_pkg::*;
#(
    parameter int MAX_LOG2_DW = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_we,
    input  logic [2:0]   cfg_addr,
    input  logic [31:0]  cfg_wdata,
    output logic [31:0]  cfg_rdata,
    input  logic         ev_valid,
    output logic         ev_ready,
    input  logic [7:0]   ev_src_id,
    input  logic [27:0]  ev_src_data,
    input  logic [7:0]   ev_ring_id,
    input  logic [7:0]   ev_vmid,
    input  logic [15:0]  ev_pasid,
    output logic         mem_req_valid,
    input  logic         mem_req_ready,
    output logic [39:0]  mem_req_addr,
    output logic [127:0] mem_req_data,
    output logic         mem_req_wb,
    output logic         irq,
    output logic         busy
);
    localparam int PTR_W = MAX_LOG2_DW + 2;

    logic              ring_en, intr_en, ovf_en, wb_en, rearm;
    logic [31:0]       base;
    logic [ADDR_W-1:0] wb_addr;
    logic [PTR_W-1:0]  rptr_q, wptr_q, ptr_mask, sw_ptr_val;
    logic              wptr_wr, rptr_wr, ovf_clr;
    logic              ovf_q;
    logic [31:0]       wptr_report;
    logic              pending;
    ivr_event_t        ev;

    assign ev = '{pasid: ev_pasid, vmid: ev_vmid, ring_id: ev_ring_id,
                  src_data: ev_src_data, src_id: ev_src_id};

    ivr_regs #(.MAX_LOG2_DW(MAX_LOG2_DW), .PTR_W(PTR_W)) u_regs (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .wptr_report(wptr_report),
        .ring_en(ring_en), .intr_en(intr_en), .ovf_en(ovf_en),
        .wb_en(wb_en), .rearm(rearm), .base(base), .wb_addr(wb_addr),
        .rptr(rptr_q), .ptr_mask(ptr_mask), .sw_ptr_val(sw_ptr_val),
        .wptr_wr(wptr_wr), .rptr_wr(rptr_wr), .ovf_clr(ovf_clr)
    );

    ivr_ctrl #(.PTR_W(PTR_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .ring_en(ring_en), .intr_en(intr_en), .ovf_en(ovf_en), .wb_en(wb_en),
        .base(base), .wb_addr(wb_addr), .rptr(rptr_q), .ptr_mask(ptr_mask),
        .sw_ptr_val(sw_ptr_val), .wptr_wr(wptr_wr), .ovf_clr(ovf_clr),
        .ev_valid(ev_valid), .ev(ev), .ev_ready(ev_ready),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
        .mem_req_wb(mem_req_wb), .busy(busy),
        .wptr(wptr_q), .ovf_flag(ovf_q), .wptr_report(wptr_report)
    );

    assign pending = (wptr_q != rptr_q) || ovf_q;

    ivr_irq u_irq (
        .clk(clk), .rst(rst), .intr_en(intr_en), .rearm(rearm),
        .pending(pending), .rptr_wr(rptr_wr), .irq(irq)
    );
endmodule

// File: rtl/ivr_checker.sv
module ivr_checker #(
    parameter int PTR_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic             ev_valid,
    input logic             ev_ready,
    input logic             busy,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [39:0]      mem_req_addr,
    input logic [127:0]     mem_req_data,
    input logic             irq,
    input logic             rearm,
    input logic             ovf_en,
    input logic             ovf_flag,
    input logic [PTR_W-1:0] wptr,
    input logic [PTR_W-1:0] rptr
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready && !cfg_we |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data));

    // R10
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        ev_valid && ev_ready |=> busy && !ev_ready);

    // R2
    ptr_align_chk: assert property (@(posedge clk) disable iff (rst)
        (wptr[3:0] == 4'h0) && (rptr[3:0] == 4'h0));

    // R7
    irq_pending_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (wptr != rptr) || ovf_flag);

    // R4
    ovf_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> $past(ovf_en));

    // R8
    rearm_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rearm && irq && !cfg_we |=> !irq);
endmodule

bind ivr_writer ivr_checker #(.PTR_W(PTR_W)) u_ivr_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
    .irq(irq), .rearm(rearm), .ovf_en(ovf_en), .ovf_flag(ovf_q),
    .wptr(wptr_q), .rptr(rptr_q)
);

// File: tb/tb_ivr_writer.sv
module tb_ivr_writer;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_we = 1'b0;
    logic [2:0]   cfg_addr = 3'd0;
    logic [31:0]  cfg_wdata = 32'h0;
    logic [31:0]  cfg_rdata;
    logic         ev_valid = 1'b0;
    logic         ev_ready;
    logic [7:0]   ev_src_id = 8'h0;
    logic [27:0]  ev_src_data = 28'h0;
    logic [7:0]   ev_ring_id = 8'h0;
    logic [7:0]   ev_vmid = 8'h0;
    logic [15:0]  ev_pasid = 16'h0;
    logic         mem_req_valid;
    logic         mem_req_ready = 1'b1;
    logic [39:0]  mem_req_addr;
    logic [127:0] mem_req_data;
    logic         mem_req_wb;
    logic         irq;
    logic         busy;

    always #10 clk = ~clk;

    ivr_writer dut (.*);

    typedef struct {
        logic [39:0]  addr;
        logic [127:0] data;
        logic         wb;
    } exp_t;
    exp_t exp_q[$];

    int n_chk = 0;
    int n_fail = 0;
    int irq_cnt = 0;

    // Bench model state
    logic [31:0] m_base = 32'h0;
    logic [39:0] m_wb_addr = 40'h0;
    int unsigned m_size = 0;
    logic [15:0] m_wptr = 16'h0;
    logic [15:0] m_rptr = 16'h0;
    logic        m_flag = 1'b0;
    logic        m_ovf_en = 1'b0;
    logic        m_wb_en = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mask_of(int unsigned sz);
        int unsigned s;
        s = (sz < 3) ? 3 : ((sz > 14) ? 14 : sz);
        return 16'((32'd1 << (s + 2)) - 1);
    endfunction

    function automatic logic [127:0] exp_vector(logic [7:0] id, logic [27:0] d,
                                                logic [7:0] rg, logic [7:0] vm,
                                                logic [15:0] pa);
        logic [127:0] v;
        v = '0;
        v[7:0]    = id;
        v[59:32]  = d;
        v[71:64]  = rg;
        v[79:72]  = vm;
        v[95:80]  = pa;
        return v;
    endfunction

    // Monitor: compare each memory handshake with the oldest expected item.
    always @(negedge clk) begin
        #1;
        if (!rst && mem_req_valid && mem_req_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3/R6", "unexpected request addr", 128'(mem_req_addr), 128'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(mem_req_wb == e.wb, "R6", "request kind", 128'(mem_req_wb), 128'(e.wb));
                chk(mem_req_addr == e.addr, "R2/R6", "request address",
                    128'(mem_req_addr), 128'(e.addr));
                chk(mem_req_data == e.data, "R1/R6", "request data", mem_req_data, e.data);
            end
        end
        if (irq) irq_cnt++;
    end

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic set_ctrl(input bit ring, input bit intr, input bit ovf, input bit wb,
                            input bit rearm, input bit clr, input int unsigned sz);
        m_size = sz; m_ovf_en = ovf; m_wb_en = wb;
        if (clr) m_flag = 1'b0;
        cfg_write(3'd0, {19'h0, 5'(sz), 2'b00, clr, rearm, wb, ovf, intr, ring});
    endtask

    task automatic send_nowait(input logic [7:0] id, input logic [27:0] d,
                               input logic [7:0] rg, input logic [7:0] vm,
                               input logic [15:0] pa);
        exp_t e;
        logic [15:0] nxt;
        ev_valid = 1'b1; ev_src_id = id; ev_src_data = d;
        ev_ring_id = rg; ev_vmid = vm; ev_pasid = pa;
        while (!ev_ready) @(negedge clk);
        e.addr = {m_base, 8'h00} + 40'(m_wptr);
        e.data = exp_vector(id, d, rg, vm, pa);
        e.wb = 1'b0;
        exp_q.push_back(e);
        nxt = (m_wptr + 16'd16) & mask_of(m_size);
        if (m_ovf_en && nxt == m_rptr) m_flag = 1'b1;
        m_wptr = nxt;
        if (m_wb_en) begin
            e.addr = m_wb_addr;
            e.data = {96'h0, 16'h0, m_wptr | {15'h0, m_flag}};
            e.wb = 1'b1;
            exp_q.push_back(e);
        end
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int guard;
        guard = 0;
        while (busy && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        #2;
    endtask

    task automatic send(input logic [7:0] id, input logic [27:0] d,
                        input logic [7:0] rg, input logic [7:0] vm,
                        input logic [15:0] pa);
        send_nowait(id, d, rg, vm, pa);
        wait_idle();
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        chk(ev_ready == 1'b0, "R3", "ev_ready after reset", 128'(ev_ready), 128'h0);
        chk(irq == 1'b0, "R7", "irq after reset", 128'(irq), 128'h0);
        chk(busy == 1'b0, "R10", "busy after reset", 128'(busy), 128'h0);
        cfg_read(3'd5, rd);
        chk(rd == 32'h0, "R9", "wptr after reset", 128'(rd), 128'h0);

        // R3: events while disabled are ignored
        ev_valid = 1'b1; ev_src_id = 8'h55;
        repeat (5) @(negedge clk);
        chk(ev_ready == 1'b0, "R3", "ev_ready while disabled", 128'(ev_ready), 128'h0);
        ev_valid = 1'b0;
        cfg_read(3'd5, rd);
        chk(rd == 32'h0, "R3", "wptr after disabled events", 128'(rd), 128'h0);

        // Configure: 64-byte ring, overflow detect, writeback
        m_base = 32'h0012_3456;
        m_wb_addr = {8'hAB, 32'h0000_1000};
        cfg_write(3'd1, m_base);
        cfg_write(3'd2, 32'h0000_1000);
        cfg_write(3'd3, 32'h0000_00AB);
        set_ctrl(1, 1, 1, 1, 0, 0, 4);

        // R1/R2/R6: distinct field patterns
        send(8'hA1, 28'h123_4567, 8'h3C, 8'h5A, 16'hBEEF);
        chk(irq == 1'b1, "R7", "irq with one unread vector", 128'(irq), 128'h1);
        send(8'hFF, 28'hFFF_FFFF, 8'h00, 8'hFF, 16'h0000);
        send(8'h00, 28'h000_0001, 8'hFF, 8'h00, 16'hFFFF);
        // R4: this one fills the last slot and wraps to zero
        send(8'h7E, 28'hA5A_5A5A, 8'h81, 8'h18, 16'h1234);
        cfg_read(3'd5, rd);
        chk(rd == 32'h1, "R4", "wptr with overflow flag", 128'(rd), 128'h1);
        chk(irq == 1'b1, "R7", "irq held by overflow flag", 128'(irq), 128'h1);

        // R5: flag survives a read-pointer write, cleared by control bit 5
        cfg_write(3'd4, 32'h10); m_rptr = 16'h10;
        cfg_read(3'd5, rd);
        chk(rd == 32'h1, "R5", "flag after rptr write", 128'(rd), 128'h1);
        set_ctrl(1, 1, 1, 1, 0, 1, 4);
        cfg_read(3'd5, rd);
        chk(rd == 32'h0, "R5", "flag after clear", 128'(rd), 128'h0);
        chk(irq == 1'b1, "R7", "irq with wptr!=rptr", 128'(irq), 128'h1);
        cfg_write(3'd4, 32'h0); m_rptr = 16'h0;
        chk(irq == 1'b0, "R7", "irq with empty ring", 128'(irq), 128'h0);

        // R4: overflow detect off, fill and wrap without flag
        set_ctrl(1, 1, 0, 0, 0, 0, 4);
        for (int i = 0; i < 4; i++)
            send(8'(i + 16), 28'(i * 3), 8'(i), 8'(i + 1), 16'(i + 2));
        cfg_read(3'd5, rd);
        chk(rd == 32'h0, "R4", "wrap without overflow detect", 128'(rd), 128'h0);

        // R8: rearm mode
        set_ctrl(1, 1, 0, 0, 1, 0, 4);
        irq_cnt = 0;
        send(8'h42, 28'h0ABC_DEF, 8'h01, 8'h02, 16'h0003);
        repeat (8) @(negedge clk);
        chk(irq_cnt == 1, "R8", "pulses after event", 128'(irq_cnt), 128'h1);
        irq_cnt = 0;
        cfg_write(3'd4, 32'h0);
        repeat (8) @(negedge clk);
        chk(irq_cnt == 1, "R8", "pulses after rearm while pending", 128'(irq_cnt), 128'h1);
        irq_cnt = 0;
        cfg_write(3'd4, 32'h10); m_rptr = 16'h10;
        repeat (8) @(negedge clk);
        chk(irq_cnt == 0, "R8", "pulses after emptying", 128'(irq_cnt), 128'h0);

        // R9: pointer writes masked and aligned
        cfg_write(3'd4, 32'hFFFF_FFF7);
        cfg_read(3'd4, rd);
        chk(rd == 32'h30, "R9", "rptr masked to 64-byte ring", 128'(rd), 128'h30);
        set_ctrl(1, 1, 0, 0, 0, 0, 0);
        cfg_write(3'd4, 32'h7F);
        cfg_read(3'd4, rd);
        chk(rd == 32'h10, "R2", "size clamped to minimum", 128'(rd), 128'h10);
        cfg_write(3'd5, 32'h0); cfg_write(3'd4, 32'h0);
        m_wptr = 16'h0; m_rptr = 16'h0;
        cfg_read(3'd5, rd);
        chk(rd == 32'h0 && irq == 1'b0, "R9", "pointers zeroed", 128'(rd), 128'h0);

        // R10/R11: stalled memory port
        set_ctrl(1, 1, 0, 1, 0, 0, 4);
        mem_req_ready = 1'b0;
        send_nowait(8'h99, 28'h1111_111, 8'h22, 8'h33, 16'h4444);
        repeat (5) @(negedge clk);
        chk(busy == 1'b1, "R10", "busy during stall", 128'(busy), 128'h1);
        chk(ev_ready == 1'b0, "R3", "ev_ready during stall", 128'(ev_ready), 128'h0);
        chk(mem_req_valid == 1'b1, "R11", "request held", 128'(mem_req_valid), 128'h1);
        mem_req_ready = 1'b1;
        wait_idle();
        chk(busy == 1'b0, "R10", "busy after completion", 128'(busy), 128'h0);

        // R3: ring disabled again
        set_ctrl(0, 1, 0, 0, 0, 0, 4);
        ev_valid = 1'b1;
        repeat (4) @(negedge clk);
        ev_valid = 1'b0;
        cfg_read(3'd5, rd);
        chk(rd == 32'h10, "R3", "wptr unchanged when disabled", 128'(rd), 128'h10);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R6", "expected requests left", 128'(exp_q.size()), 128'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule